// File: doc/BRIEF.md
# CAN Controller Power-Mode Manager

This block decides when the module clocks of a CAN protocol controller may be switched off and when they must come back. Software programs four control bits through a simple write port: a stop request, a bus-activity wake enable, an automatic idle power-save enable and a bit that restricts the control register to supervisor accesses. The protocol engine reports whether it has work pending. From these the block drives a clock-enable for the gated part of the module and a stop-acknowledge status that software polls.

All logic in this block runs on an always-on clock. The receive line is synchronized and watched for a falling edge, a change from the recessive level (1) to the dominant level (0), even while the module clocks are off. When wake on bus activity is enabled, such an edge clears the stop request by itself and the clocks restart with no CPU action. A write that sets the wake enable in the same cycle as a detected edge is defined to leave the wake bit clear and the clocks running.

Top module: `can_pwr_mgr`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), rd_stop, rd_selfwake, rd_aps, stop_ack and acc_err are 0, rd_supv is 1 and clk_en is 1.
- R2: An accepted write (wr_en high) loads wr_stop, wr_selfwake, wr_aps and wr_supv into the control bits, visible on the rd_* outputs after the next clock edge.
- R3: A write is accepted when rd_supv is 0 or priv_super is 1. A write with rd_supv 1 and priv_super 0 leaves all control bits unchanged and raises acc_err for exactly the one cycle after that edge.
- R4: While the stop bit is set, clk_en goes low one edge after eng_busy is seen low, stays high as long as eng_busy is high before that, and once low stays low until the stop bit clears.
- R5: stop_ack equals, one edge later, the stop bit being set while clk_en is low; it therefore rises exactly one cycle after clk_en falls under a stop request and drops on the edge where clk_en returns after the stop bit clears.
- R6: rx_async is passed through two synchronizer flops; a 1-to-0 change is detected when the second flop holds 0 and held 1 one cycle earlier. With the wake bit and the stop bit both set, that detection clears the stop bit on the third clock edge after rx_async falls, and clk_en returns on the fourth.
- R7: If an accepted write with wr_selfwake 1 lands on the cycle of a detected bus edge, the wake bit stays 0 and the stop bit is 0 afterwards, whatever wr_stop was, so clk_en never drops.
- R8: With the auto power-save bit set and stop clear, clk_en follows eng_busy one edge later: low while no work is pending, high again when work appears.
- R9: With both the stop bit and the auto power-save bit clear, clk_en is 1 on every cycle after the next edge.
- R10: With the wake bit clear, bus edges have no effect on the stop bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Control register write strobe |
| wr_stop | input | 1 | Write data: stop request |
| wr_selfwake | input | 1 | Write data: wake on bus activity enable |
| wr_aps | input | 1 | Write data: automatic idle power-save enable |
| wr_supv | input | 1 | Write data: supervisor-only access |
| priv_super | input | 1 | 1 when the current access is in supervisor mode |
| rx_async | input | 1 | Bus receive line, asynchronous, 1 recessive |
| eng_busy | input | 1 | Protocol engine has work pending |
| clk_en | output | 1 | Module clock enable |
| stop_ack | output | 1 | Stop mode reached with clocks off |
| acc_err | output | 1 | One-cycle pulse on a refused user write |
| rd_stop | output | 1 | Current stop request bit |
| rd_selfwake | output | 1 | Current wake enable bit |
| rd_aps | output | 1 | Current auto power-save bit |
| rd_supv | output | 1 | Current supervisor-only bit |

## Verification
The bench aims at the cycle where a wake-enable write coincides with the detected bus edge; a design that applied the write would leave the wake bit set and gate the clocks with no further edge to wake them. It holds eng_busy high across a stop request, where a design that gated at once would cut the engine off mid-task, and checks that stop_ack trails clk_en by one cycle rather than arriving with the request. It also sends bus edges with the wake bit clear and user writes to a protected register, where a careless design would drop the stop request or change the control bits.

// File: rtl/can_pwr_pkg.sv
// Package: shared types for the CAN power-mode manager.
// Assumes: control bits are single-bit flags kept together in one struct.
package can_pwr_pkg;

    typedef struct packed {
        logic stop;
        logic selfwake;
        logic aps;
        logic supv;
    } pwr_ctl_t;

    localparam pwr_ctl_t CTL_RESET = '{stop: 1'b0, selfwake: 1'b0, aps: 1'b0, supv: 1'b1};

endpackage

// File: rtl/can_pwr_rxsync.sv
// Module: can_pwr_rxsync
// Synchronizes the asynchronous receive line into the always-on domain and
// flags a recessive-to-dominant (1 to 0) change for one cycle.
// Assumes: SYNC_STAGES >= 2, idle bus level is IDLE_LEVEL.
module can_pwr_rxsync #(
    parameter int   SYNC_STAGES = 2,
    parameter logic IDLE_LEVEL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_async,
    output logic fall_det
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] chain;
    logic          prev_lvl;

    // Shift the raw line through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {SYNC_STAGES{IDLE_LEVEL}};
        end else begin
            chain <= {chain[LAST-1:0], rx_async};
        end
    end

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_lvl <= IDLE_LEVEL;
        end else begin
            prev_lvl <= chain[LAST];
        end
    end

    // A dominant level following a recessive one is a wake edge.
    always_comb begin
        fall_det = prev_lvl & ~chain[LAST];
    end

endmodule

// File: rtl/can_pwr_ctlreg.sv
// Module: can_pwr_ctlreg
// Holds the power-mode control bits, applies the privilege check on writes,
// clears the stop request on a bus wake and resolves the write/edge race.
// Assumes: one write per cycle, fall_det is a single-cycle pulse.
module can_pwr_ctlreg
    import can_pwr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  pwr_ctl_t wr_data,
    input  logic     priv_super,
    input  logic     fall_det,
    output pwr_ctl_t ctl,
    output logic     acc_err
);
    logic     wr_ok;
    logic     wr_denied;
    pwr_ctl_t ctl_nxt;

    // Decide whether the write passes the privilege check.
    always_comb begin
        wr_ok     = wr_en & (~ctl.supv | priv_super);
        wr_denied = wr_en & ctl.supv & ~priv_super;
    end

    // Merge the write, the race rule and the bus wake into the next value.
    always_comb begin
        ctl_nxt = wr_ok ? wr_data : ctl;
        if (fall_det && wr_ok && wr_data.selfwake) begin
            ctl_nxt.selfwake = 1'b0;
            ctl_nxt.stop     = 1'b0;
        end
        if (fall_det && ctl.selfwake) begin
            ctl_nxt.stop = 1'b0;
        end
    end

    // Register the control bits and the access error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl     <= CTL_RESET;
            acc_err <= 1'b0;
        end else begin
            ctl     <= ctl_nxt;
            acc_err <= wr_denied;
        end
    end

endmodule

// File: rtl/can_pwr_gate.sv
// Module: can_pwr_gate
// Drives the module clock enable and the stop acknowledge from the control
// bits and the engine busy flag.
// Assumes: eng_busy is produced in the always-on domain.
module can_pwr_gate
    import can_pwr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pwr_ctl_t ctl,
    input  logic     eng_busy,
    output logic     clk_en,
    output logic     stop_ack
);
    logic en_nxt;

    // Choose the next clock enable: stop latches off, idle save follows busy.
    always_comb begin
        if (ctl.stop) begin
            en_nxt = clk_en & eng_busy;
        end else if (ctl.aps) begin
            en_nxt = eng_busy;
        end else begin
            en_nxt = 1'b1;
        end
    end

    // Register the enable and report stop once clocks are already off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_en   <= 1'b1;
            stop_ack <= 1'b0;
        end else begin
            clk_en   <= en_nxt;
            stop_ack <= ctl.stop & ~clk_en;
        end
    end

endmodule

// File: rtl/can_pwr_mgr.sv
// Module: can_pwr_mgr (top)
// Power-mode manager of a CAN controller: gates module clocks on stop or
// idle, restarts them on work or bus activity.
// Assumes: clk is always running; rx_async is asynchronous to it.
module can_pwr_mgr
    import can_pwr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_stop,
    input  logic wr_selfwake,
    input  logic wr_aps,
    input  logic wr_supv,
    input  logic priv_super,
    input  logic rx_async,
    input  logic eng_busy,
    output logic clk_en,
    output logic stop_ack,
    output logic acc_err,
    output logic rd_stop,
    output logic rd_selfwake,
    output logic rd_aps,
    output logic rd_supv
);
    pwr_ctl_t wr_data;
    pwr_ctl_t ctl;
    logic     bus_fall;

    // Pack the write data fields.
    always_comb begin
        wr_data = '{stop: wr_stop, selfwake: wr_selfwake, aps: wr_aps, supv: wr_supv};
    end

    can_pwr_rxsync #(
        .SYNC_STAGES (SYNC_STAGES),
        .IDLE_LEVEL  (1'b1)
    ) u_rxsync (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_async (rx_async),
        .fall_det (bus_fall)
    );

    can_pwr_ctlreg u_ctlreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .priv_super (priv_super),
        .fall_det   (bus_fall),
        .ctl        (ctl),
        .acc_err    (acc_err)
    );

    can_pwr_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl      (ctl),
        .eng_busy (eng_busy),
        .clk_en   (clk_en),
        .stop_ack (stop_ack)
    );

    // Expose the control bits for read-back.
    always_comb begin
        rd_stop     = ctl.stop;
        rd_selfwake = ctl.selfwake;
        rd_aps      = ctl.aps;
        rd_supv     = ctl.supv;
    end

endmodule

// File: rtl/can_pwr_mgr_chk.sv
// Module: can_pwr_mgr_chk
// Property checker for can_pwr_mgr, attached by bind.
// Assumes: sampled on the always-on clock.
module can_pwr_mgr_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic wr_selfwake,
    input logic priv_super,
    input logic eng_busy,
    input logic bus_fall,
    input logic clk_en,
    input logic stop_ack,
    input logic acc_err,
    input logic rd_stop,
    input logic rd_selfwake,
    input logic rd_aps,
    input logic rd_supv
);
    p_reset_vals_r1: assert property (@(posedge clk)
        !rst_n |=> (clk_en && !stop_ack && !acc_err && !rd_stop && !rd_selfwake && !rd_aps && rd_supv));

    p_user_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_supv && !priv_super) |=> (acc_err && $stable(rd_aps) && $stable(rd_supv)));

    p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && eng_busy) |=> clk_en);

    p_ack_trail_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stop && !clk_en) |=> stop_ack);

    p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |=> !stop_ack);

    p_bus_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_fall && rd_selfwake && rd_stop) |=> !rd_stop);

    p_race_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_fall && wr_en && wr_selfwake && (!rd_supv || priv_super)) |=> (!rd_selfwake && !rd_stop));

    p_aps_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_aps && !rd_stop && eng_busy) |=> clk_en);

    p_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stop && !rd_aps) |=> clk_en);

endmodule

bind can_pwr_mgr can_pwr_mgr_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_selfwake (wr_selfwake),
    .priv_super  (priv_super),
    .eng_busy    (eng_busy),
    .bus_fall    (bus_fall),
    .clk_en      (clk_en),
    .stop_ack    (stop_ack),
    .acc_err     (acc_err),
    .rd_stop     (rd_stop),
    .rd_selfwake (rd_selfwake),
    .rd_aps      (rd_aps),
    .rd_supv     (rd_supv)
);

// File: tb/can_pwr_mgr_test.sv
`timescale 1ns/1ps
// Bench for can_pwr_mgr: behavioural reference compared every cycle plus
// directed checks per requirement.
module can_pwr_mgr_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, wr_stop = 1'b0, wr_selfwake = 1'b0, wr_aps = 1'b0, wr_supv = 1'b0;
    logic priv_super = 1'b1;
    logic rx_async = 1'b1;
    logic eng_busy = 1'b0;
    logic clk_en, stop_ack, acc_err, rd_stop, rd_selfwake, rd_aps, rd_supv;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    can_pwr_mgr uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_stop(wr_stop),
        .wr_selfwake(wr_selfwake), .wr_aps(wr_aps), .wr_supv(wr_supv),
        .priv_super(priv_super), .rx_async(rx_async), .eng_busy(eng_busy),
        .clk_en(clk_en), .stop_ack(stop_ack), .acc_err(acc_err),
        .rd_stop(rd_stop), .rd_selfwake(rd_selfwake), .rd_aps(rd_aps), .rd_supv(rd_supv)
    );

    // Reference model state
    bit m_stop, m_swk, m_aps, m_supv, m_clk, m_ack, m_err;
    bit rx_hist[$];   // synchronizer contents, newest first, then previous level

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference update on every edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_stop = 0; m_swk = 0; m_aps = 0; m_supv = 1; m_clk = 1; m_ack = 0; m_err = 0;
            rx_hist = '{1'b1, 1'b1, 1'b1};
        end else begin
            bit edge_seen, allowed, n_stop, n_swk, n_aps, n_supv, n_clk;
            edge_seen = rx_hist[2] && !rx_hist[1];
            allowed = wr_en && (!m_supv || priv_super);
            n_stop = m_stop; n_swk = m_swk; n_aps = m_aps; n_supv = m_supv;
            if (allowed) begin
                n_stop = wr_stop; n_swk = wr_selfwake; n_aps = wr_aps; n_supv = wr_supv;
            end
            if (edge_seen && allowed && wr_selfwake) begin n_swk = 0; n_stop = 0; end
            if (edge_seen && m_swk) n_stop = 0;
            if (m_stop)     n_clk = m_clk && eng_busy;
            else if (m_aps) n_clk = eng_busy;
            else            n_clk = 1;
            m_ack = m_stop && !m_clk;
            m_err = wr_en && m_supv && !priv_super;
            m_stop = n_stop; m_swk = n_swk; m_aps = n_aps; m_supv = n_supv; m_clk = n_clk;
            void'(rx_hist.pop_back());
            rx_hist.push_front(rx_async);
        end
    end

    // Compare outputs with the model on every falling edge.
    always @(negedge clk) begin
        if (!done) begin
            check(clk_en == m_clk,     "R4 clk_en",   clk_en,   m_clk);
            check(stop_ack == m_ack,   "R5 stop_ack", stop_ack, m_ack);
            check(acc_err == m_err,    "R3 acc_err",  acc_err,  m_err);
            check({rd_stop, rd_selfwake, rd_aps, rd_supv} == {m_stop, m_swk, m_aps, m_supv},
                  "R2 control bits", {rd_stop, rd_selfwake, rd_aps, rd_supv}, {m_stop, m_swk, m_aps, m_supv});
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input bit s, input bit w, input bit a, input bit v, input bit sup);
        wr_en = 1; wr_stop = s; wr_selfwake = w; wr_aps = a; wr_supv = v; priv_super = sup;
        tick(1);
        wr_en = 0; priv_super = 1;
    endtask

    initial begin
        tick(2);
        // R1 reset values
        check(clk_en == 1 && stop_ack == 0 && acc_err == 0, "R1 outputs", {clk_en, stop_ack, acc_err}, 3'b100);
        check({rd_stop, rd_selfwake, rd_aps, rd_supv} == 4'b0001, "R1 control bits",
              {rd_stop, rd_selfwake, rd_aps, rd_supv}, 4'b0001);
        rst_n = 1;
        tick(1);

        // R2 / R8: auto power save
        wr(0, 0, 1, 1, 1);
        check(rd_aps == 1, "R2 aps loaded", rd_aps, 1);
        tick(1);
        check(clk_en == 0, "R8 idle gated", clk_en, 0);
        eng_busy = 1; tick(1);
        check(clk_en == 1, "R8 restart on work", clk_en, 1);
        eng_busy = 0;
        wr(0, 0, 0, 1, 1);
        tick(3);
        check(clk_en == 1, "R9 runs normally", clk_en, 1);

        // R3 privilege
        wr(0, 0, 1, 1, 0);
        check(acc_err == 1 && rd_aps == 0, "R3 user write refused", {acc_err, rd_aps}, 2'b10);
        tick(1);
        check(acc_err == 0, "R3 error is one pulse", acc_err, 0);
        wr(0, 0, 0, 0, 1);
        wr(0, 0, 1, 0, 0);
        check(rd_aps == 1 && acc_err == 0, "R3 user write allowed", {rd_aps, acc_err}, 2'b10);
        wr(0, 0, 0, 1, 1);

        // R4 / R5 stop with busy engine
        eng_busy = 1;
        wr(1, 0, 0, 1, 1);
        tick(3);
        check(clk_en == 1, "R4 busy holds clocks", clk_en, 1);
        eng_busy = 0; tick(1);
        check(clk_en == 0 && stop_ack == 0, "R5 ack not yet", {clk_en, stop_ack}, 2'b00);
        tick(1);
        check(stop_ack == 1, "R5 ack one cycle later", stop_ack, 1);
        eng_busy = 1; tick(2);
        check(clk_en == 0, "R4 stays gated", clk_en, 0);
        eng_busy = 0;

        // R10 bus edge ignored without wake enable
        rx_async = 0; tick(5);
        check(rd_stop == 1 && clk_en == 0, "R10 stop kept", {rd_stop, clk_en}, 2'b10);
        rx_async = 1; tick(3);
        wr(0, 0, 0, 1, 1);
        tick(1);
        check(clk_en == 1 && stop_ack == 0, "R5 ack clears with clocks", {clk_en, stop_ack}, 2'b10);

        // R6 self wake
        wr(1, 1, 0, 1, 1);
        tick(3);
        check(stop_ack == 1, "R6 stopped before wake", stop_ack, 1);
        rx_async = 0;
        tick(3);
        check(rd_stop == 0 && clk_en == 0, "R6 stop cleared by edge", {rd_stop, clk_en}, 2'b00);
        tick(1);
        check(clk_en == 1 && stop_ack == 0, "R6 clocks back", {clk_en, stop_ack}, 2'b10);
        rx_async = 1; tick(3);

        // R7 race of wake enable write with bus edge
        wr(0, 0, 0, 1, 1);
        tick(2);
        rx_async = 0;
        tick(2);
        wr(1, 1, 0, 1, 1);
        check(rd_selfwake == 0 && rd_stop == 0, "R7 race write", {rd_selfwake, rd_stop}, 2'b00);
        tick(4);
        check(clk_en == 1, "R7 clocks never stop", clk_en, 1);
        rx_async = 1; tick(4);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule